// File: doc/BRIEF.md
# Refresh Scheduler for an Eight-Bank Mobile DRAM

This block decides when a memory controller must refresh an eight-bank mobile DRAM. A free-running interval counter adds one refresh to an internal debt at each interval. The interval is the average all-bank interval in all-bank mode, and one eighth of it in per-bank mode. That rate gives 8192 refreshes in a 32 ms window at the nominal 3.9 us / 0.4875 us spacing. While debt is outstanding the block raises a request, which the controller answers with a one-cycle grant.

A grant retires one unit of debt. It starts a busy window as long as the refresh cycle time of the current mode: 130 ns class for all-bank and 60 ns class for per-bank, both given in clock cycles. In per-bank mode a grant also moves the target bank to the next index. While the controller reports that it is busy, refreshes are postponed and the debt grows. When the debt reaches its bound, the request becomes urgent and is raised whether or not the controller is busy. Once the controller is free, the scheduler keeps requesting back to back, one per busy window, until the debt is paid.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, ref_req, ref_urgent and rfc_busy are 0 and ref_bank is 0.
- R2: In all-bank mode (mode_per_bank=0), with ctrl_busy=0, ref_req first rises exactly ALL_CYC clock edges after reset is released, and ref_all_banks reads 1.
- R3: In per-bank mode (mode_per_bank=1), debt accrues every ALL_CYC/NUM_BANKS edges, so ref_req first rises exactly ALL_CYC/NUM_BANKS edges after reset.
- R4: In per-bank mode each accepted grant advances ref_bank by one, 0 through NUM_BANKS-1, then wraps to 0. In all-bank mode ref_bank does not change.
- R5: A grant accepted while ref_req=1 makes rfc_busy 1 for exactly TRFC_AB_CYC cycles (all-bank) or TRFC_PB_CYC cycles (per-bank). ref_req is 0 during that window.
- R6: While ctrl_busy=1 and the debt is below MAX_DEBT, ref_req stays 0.
- R7: The debt saturates at MAX_DEBT. At that level ref_urgent=1, and ref_req is raised even with ctrl_busy=1. Intervals that elapse while the debt is saturated are dropped.
- R8: Each accepted grant retires exactly one refresh. After a busy window, ref_req rises again while debt remains and stays 0 once the debt is 0.
- R9: A grant that arrives while ref_req=0 is ignored. It starts no busy window, moves no bank and retires no debt.
- R10: When an interval elapses in the same cycle as an accepted grant, the debt is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_per_bank | input | 1 | 1 = per-bank refresh, 0 = all-bank refresh |
| ctrl_busy | input | 1 | Controller wants to postpone refresh |
| ref_grant | input | 1 | Controller issues the requested refresh this cycle |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Postponement bound reached |
| ref_all_banks | output | 1 | Requested refresh covers all banks |
| ref_bank | output | $clog2(NUM_BANKS) | Target bank for a per-bank refresh |
| rfc_busy | output | 1 | Refresh cycle time window in progress |

## Verification
The interval tick and an accepted grant can land on the same clock edge. In that case the debt must neither grow nor shrink. The bench lets one refresh go unanswered, then places a grant on exactly the edge where the second interval elapses. It then checks that one request returns after the busy window and that no request remains after one further grant. A second overlap comes from saturation: grants are made after a tick was dropped at the cap, and the bench counts that exactly MAX_DEBT grants empty the debt.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   typedef enum logic {
      RS_MODE_ALL  = 1'b0,
      RS_MODE_BANK = 1'b1
   } rs_mode_e;

   function automatic int unsigned rs_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/refsched_tick.sv
module refsched_tick
   import refsched_pkg::*;
#(
   parameter int unsigned ALL_CYC   = 1560,
   parameter int unsigned NUM_BANKS = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  rs_mode_e mode,
   output logic     tick
);
   localparam int unsigned PB_CYC = ALL_CYC / NUM_BANKS;
   localparam int unsigned CW     = rs_width(ALL_CYC);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   always_comb begin
      limit = (mode == RS_MODE_BANK) ? CW'(PB_CYC - 1) : CW'(ALL_CYC - 1);
      tick  = (cnt >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R3: even the short interval spans at least two cycles
   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
   parameter int unsigned MAX_DEBT = 8,
   parameter int unsigned DW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          take,
   output logic [DW-1:0] debt,
   output logic          pending,
   output logic          full
);
   always_comb begin
      pending = (debt != '0);
      full    = (debt == DW'(MAX_DEBT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt <= '0;
      end else begin
         unique case ({tick, take})
            2'b10:   if (!full) debt <= debt + 1'b1;
            2'b01:   debt <= debt - 1'b1;
            default: ;
         endcase
      end
   end

   assert_debt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= DW'(MAX_DEBT));

   assert_tick_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && take) |=> $stable(debt));

   assert_take_needs_debt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pending);

endmodule

// File: rtl/refsched_busy.sv
module refsched_busy
   import refsched_pkg::*;
#(
   parameter int unsigned TRFC_AB_CYC = 52,
   parameter int unsigned TRFC_PB_CYC = 24
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  rs_mode_e mode,
   output logic     busy
);
   localparam int unsigned TMAX = (TRFC_AB_CYC > TRFC_PB_CYC) ? TRFC_AB_CYC : TRFC_PB_CYC;
   localparam int unsigned TW   = rs_width(TMAX);

   logic [TW-1:0] timer;
   logic [TW-1:0] load_val;

   always_comb begin
      load_val = (mode == RS_MODE_BANK) ? TW'(TRFC_PB_CYC) : TW'(TRFC_AB_CYC);
      busy     = (timer != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     timer <= '0;
      else if (start) timer <= load_val;
      else if (busy)  timer <= timer - 1'b1;
   end

   assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/refsched_bank.sv
module refsched_bank #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [BW-1:0] bank
);
   localparam bit POW2 = ((NUM_BANKS & (NUM_BANKS - 1)) == 0);

   logic [BW-1:0] nxt;

   generate
      if (POW2) begin : g_wrap_free
         always_comb nxt = bank + 1'b1;
      end else begin : g_wrap_cmp
         always_comb nxt = (bank == BW'(NUM_BANKS - 1)) ? '0 : bank + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank <= '0;
      else if (adv) bank <= nxt;
   end

   assert_bank_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank <= BW'(NUM_BANKS - 1));

   assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(bank));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refsched_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 8,
   parameter int unsigned ALL_CYC     = 1560,
   parameter int unsigned TRFC_AB_CYC = 52,
   parameter int unsigned TRFC_PB_CYC = 24,
   parameter int unsigned MAX_DEBT    = 8,
   localparam int unsigned BW = $clog2(NUM_BANKS),
   localparam int unsigned DW = rs_width(MAX_DEBT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_per_bank,
   input  logic          ctrl_busy,
   input  logic          ref_grant,
   output logic          ref_req,
   output logic          ref_urgent,
   output logic          ref_all_banks,
   output logic [BW-1:0] ref_bank,
   output logic          rfc_busy
);
   initial begin
      assert (NUM_BANKS >= 2) else $error("NUM_BANKS must be at least 2");
      assert (ALL_CYC % NUM_BANKS == 0) else $error("ALL_CYC must divide by NUM_BANKS");
      assert (ALL_CYC / NUM_BANKS >= 2) else $error("per-bank interval too short");
      assert (TRFC_PB_CYC >= 1 && TRFC_AB_CYC >= TRFC_PB_CYC) else $error("bad cycle times");
      assert (MAX_DEBT >= 1) else $error("MAX_DEBT must be at least 1");
   end

   rs_mode_e      mode;
   logic          tick;
   logic          take;
   logic          pending;
   logic          full;
   logic [DW-1:0] debt;

   always_comb begin
      mode          = mode_per_bank ? RS_MODE_BANK : RS_MODE_ALL;
      ref_urgent    = full;
      ref_req       = pending && !rfc_busy && (!ctrl_busy || full);
      take          = ref_grant && ref_req;
      ref_all_banks = (mode == RS_MODE_ALL);
   end

   refsched_tick #(.ALL_CYC(ALL_CYC), .NUM_BANKS(NUM_BANKS)) u_tick (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick)
   );

   refsched_debt #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .take(take),
      .debt(debt), .pending(pending), .full(full)
   );

   refsched_busy #(.TRFC_AB_CYC(TRFC_AB_CYC), .TRFC_PB_CYC(TRFC_PB_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(take), .mode(mode), .busy(rfc_busy)
   );

   refsched_bank #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_bank (
      .clk(clk), .rst_n(rst_n), .adv(take && (mode == RS_MODE_BANK)), .bank(ref_bank)
   );

   assert_stray_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_grant && !ref_req && !rfc_busy) |=> !rfc_busy);

   assert_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_grant && ref_req) |=> (rfc_busy && !ref_req));

   assert_allbank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_per_bank && ref_grant) |=> $stable(ref_bank));

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
   localparam int unsigned NB   = 8;
   localparam int unsigned ALL  = 128;
   localparam int unsigned PB   = ALL / NB;
   localparam int unsigned TAB  = 4;
   localparam int unsigned TPB  = 2;
   localparam int unsigned MAXD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_per_bank = 1'b0;
   logic       ctrl_busy = 1'b0;
   logic       ref_grant = 1'b0;
   logic       ref_req;
   logic       ref_urgent;
   logic       ref_all_banks;
   logic [2:0] ref_bank;
   logic       rfc_busy;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   refresh_sched #(.NUM_BANKS(NB), .ALL_CYC(ALL), .TRFC_AB_CYC(TAB),
                   .TRFC_PB_CYC(TPB), .MAX_DEBT(MAXD)) uut (
      .clk(clk), .rst_n(rst_n), .mode_per_bank(mode_per_bank),
      .ctrl_busy(ctrl_busy), .ref_grant(ref_grant), .ref_req(ref_req),
      .ref_urgent(ref_urgent), .ref_all_banks(ref_all_banks),
      .ref_bank(ref_bank), .rfc_busy(rfc_busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic pb, input logic busy_in);
      ref_grant     = 1'b0;
      rst_n         = 1'b0;
      mode_per_bank = pb;
      ctrl_busy     = busy_in;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 req in reset", int'(ref_req), 0);
      chk("R1 busy in reset", int'(rfc_busy), 0);
      chk("R1 bank in reset", int'(ref_bank), 0);
      chk("R1 urgent in reset", int'(ref_urgent), 0);
      rst_n = 1'b1;
   endtask

   task automatic grant_once();
      ref_grant = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ref_grant = 1'b0;
   endtask

   task automatic wait_req(input string tag);
      int n = 0;
      while (!ref_req && n < 200) begin
         wait_edges(1);
         n++;
      end
      chk(tag, int'(ref_req), 1);
   endtask

   task automatic test_allbank();
      do_reset(1'b0, 1'b0);
      wait_edges(ALL - 1);
      chk("R2 no req before interval", int'(ref_req), 0);
      wait_edges(1);
      chk("R2 req at interval", int'(ref_req), 1);
      chk("R2 all-bank flag", int'(ref_all_banks), 1);
      grant_once();
      chk("R5 busy after all-bank grant", int'(rfc_busy), 1);
      chk("R5 no req while busy", int'(ref_req), 0);
      wait_edges(TAB - 1);
      chk("R5 busy at last all-bank cycle", int'(rfc_busy), 1);
      wait_edges(1);
      chk("R5 busy ends after all-bank window", int'(rfc_busy), 0);
      chk("R8 no req with zero debt", int'(ref_req), 0);
      chk("R4 bank held in all-bank mode", int'(ref_bank), 0);
   endtask

   task automatic test_perbank_stray();
      do_reset(1'b1, 1'b0);
      wait_edges(2);
      grant_once();
      chk("R9 stray grant starts no busy", int'(rfc_busy), 0);
      chk("R9 stray grant moves no bank", int'(ref_bank), 0);
      wait_edges(PB - 4);
      chk("R3 no req before short interval", int'(ref_req), 0);
      wait_edges(1);
      chk("R3 req at short interval", int'(ref_req), 1);
      chk("R3 per-bank flag", int'(ref_all_banks), 0);
   endtask

   task automatic test_perbank_rotation();
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < 9; i++) begin
         wait_req("R4 req for next bank");
         chk("R4 bank order", int'(ref_bank), i % 8);
         grant_once();
         if (i == 0) begin
            chk("R5 busy after per-bank grant", int'(rfc_busy), 1);
            wait_edges(TPB - 1);
            chk("R5 busy at last per-bank cycle", int'(rfc_busy), 1);
            wait_edges(1);
            chk("R5 per-bank window ends", int'(rfc_busy), 0);
         end
      end
      chk("R4 bank after wrap", int'(ref_bank), 1);
   endtask

   task automatic test_same_cycle();
      do_reset(1'b0, 1'b0);
      wait_edges(2 * ALL - 1);
      chk("R10 req pending before overlap", int'(ref_req), 1);
      grant_once();
      wait_edges(TAB);
      chk("R10 debt kept after tick and grant", int'(ref_req), 1);
      grant_once();
      wait_edges(TAB);
      chk("R10 debt cleared after second grant", int'(ref_req), 0);
   endtask

   task automatic test_postpone();
      do_reset(1'b0, 1'b1);
      wait_edges(MAXD * ALL - 1);
      chk("R6 req held while controller busy", int'(ref_req), 0);
      chk("R7 not urgent below cap", int'(ref_urgent), 0);
      wait_edges(1);
      chk("R7 urgent at cap", int'(ref_urgent), 1);
      chk("R7 urgent req overrides busy", int'(ref_req), 1);
      wait_edges(ALL + 8);
      chk("R7 still urgent after dropped tick", int'(ref_urgent), 1);
      grant_once();
      wait_edges(TAB);
      chk("R6 postponed again below cap", int'(ref_req), 0);
      chk("R7 urgent cleared after grant", int'(ref_urgent), 0);
      ctrl_busy = 1'b0;
      for (int i = 0; i < int'(MAXD) - 1; i++) begin
         wait_req("R8 catch-up req");
         grant_once();
      end
      wait_edges(TAB);
      chk("R8 debt paid after cap grants", int'(ref_req), 0);
      chk("R7 saturated tick was dropped", int'(ref_urgent), 0);
   endtask

   initial begin
      test_allbank();
      test_perbank_stray();
      test_perbank_rotation();
      test_same_cycle();
      test_postpone();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #4000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule